// File: doc/BRIEF.md
# Framer Control and Interrupt Gating Register

This block holds the control word of a line framer that runs either of two line-rate families, and it gates that framer's interrupt sources. Software reaches it through a small synchronous bus. It has a control word, a per-source interrupt enable word and a sticky interrupt status word that clears when it is read. From the control word it drives these outputs:
- a hold-in-reset line for the framing-alignment state machines;
- a two-bit framing-format code;
- a loss-of-signal output. This output merges an external loss pin with an internal detector flag, and the internal flag can be masked.

An optional auto-disable mode guards against a fault that never clears. When the status word is read, every source that was interrupting at that moment has its enable bit cleared. A stuck source therefore raises exactly one interrupt until software sets its enable again. The hardware reset input is asserted asynchronously, is released synchronously, and is the only way to return the registers to their defaults.

Top module: `framer_ctl_irq`

## Requirements
- R1: `los_out` is 1 in every cycle in which `ext_los` is 1, whatever the value of control bit 5.
- R2: With control bit 5 = 0, `int_los` has no effect on `los_out`. With bit 5 = 1, `int_los` = 1 also drives `los_out` to 1.
- R3: `fa_rst` follows control bit 4. Writing 1 and then 0 enters and leaves the framing reset. Neither write changes any other bit of the control word or of the enable word.
- R4: While `rst_n` is 0, the control, enable and status words are all 0, and so are `irq`, `fa_rst` and `fmt_code`.
- R5: `fmt_code` = {control bit 6, control bit 2}. The codes mean: 0 = E3 G.751, 1 = E3 G.832, 2 = DS3 C-bit parity, 3 = DS3 M13.
- R6: Status bit i (address 2) is set on every clock edge at which `src_evt[i]` is 1. It stays set until an edge at which address 2 is read. A read clears it unless `src_evt[i]` is 1 on that same edge.
- R7: `irq` is 1 exactly when some source has both its status bit and its enable bit (address 1) set.
- R8: With control bit 3 = 0, the default, enable bits change only through writes to address 1. A stuck source keeps `irq` asserted across status reads.
- R9: With control bit 3 = 1, a read of address 2 clears the enable bit of every source whose status and enable bits were both set before that edge. A stuck source then gives one interrupt, and gives another only after its enable bit is written to 1 again.
- R10: Control bits 7, 1 and 0 are plain storage. A read of address 0 returns the last word written to it, and a read of address 1 returns the enable bits with the unused upper bits as 0.
- R11: A write to address 2 or address 3 changes nothing. A read of address 3 returns 0, and `bus_rdata` is 0 when no read is in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low hardware reset, released synchronously |
| bus_sel | input | 1 | Bus access strobe, one cycle per access |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 2 | 0 control, 1 enable, 2 status, 3 unused |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data, combinational during a read |
| ext_los | input | 1 | External loss-of-signal input |
| int_los | input | 1 | Internal loss-of-signal detector flag |
| src_evt | input | NUM_SRC | Interrupt source events, sampled every edge |
| los_out | output | 1 | Merged loss-of-signal |
| fa_rst | output | 1 | Hold framing-alignment state machines in reset |
| fmt_code | output | 2 | Selected framing format |
| irq | output | 1 | Interrupt request |

## Verification
The bench builds the block with NUM_SRC = 6 and DATA_W = 8. This leaves the top two enable and status bits unused, so reads must return zeros in those positions. Random traffic, random events and random control words are checked against a reference model at every cycle. Directed sequences cover these cases:
- a stuck source under each interrupt mode;
- an event that lands on the edge of a status read;
- the framing reset toggle;
- every format code;
- a hardware reset in the middle of the run.

// File: rtl/fci_pkg.sv
package fci_pkg;
  localparam int ADDR_W = 2;

  localparam logic [ADDR_W-1:0] ADDR_CTRL = 2'd0;
  localparam logic [ADDR_W-1:0] ADDR_IEN  = 2'd1;
  localparam logic [ADDR_W-1:0] ADDR_STAT = 2'd2;

  // control word bit positions
  localparam int CB_FAMILY  = 6;
  localparam int CB_LOSEN   = 5;
  localparam int CB_SRST    = 4;
  localparam int CB_AUTODIS = 3;
  localparam int CB_VARIANT = 2;

  typedef enum logic [1:0] {
    FMT_E3_G751  = 2'd0,
    FMT_E3_G832  = 2'd1,
    FMT_DS3_CBIT = 2'd2,
    FMT_DS3_M13  = 2'd3
  } fmt_e;
endpackage

// File: rtl/fci_rst_sync.sv
module fci_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic rst_n_o
);
  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb sync_d = {sync_q[STAGES-2:0], 1'b1};

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) sync_q <= '0;
    else         sync_q <= sync_d;
  end

  assign rst_n_o = sync_q[STAGES-1];
endmodule

// File: rtl/fci_ctrl_reg.sv
module fci_ctrl_reg
  import fci_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wdata,
  input  logic              ext_los,
  input  logic              int_los,
  output logic [DATA_W-1:0] ctrl_q,
  output logic              los_out,
  output logic              fa_rst,
  output logic              auto_dis,
  output logic [1:0]        fmt_code
);
  logic [DATA_W-1:0] ctrl_d;
  fmt_e              fmt;

  always_comb ctrl_d = wdata;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     ctrl_q <= '0;
    else if (wr_en) ctrl_q <= ctrl_d;
  end

  always_comb begin
    los_out  = ext_los | (ctrl_q[CB_LOSEN] & int_los);
    fa_rst   = ctrl_q[CB_SRST];
    auto_dis = ctrl_q[CB_AUTODIS];
    fmt      = fmt_e'({ctrl_q[CB_FAMILY], ctrl_q[CB_VARIANT]});
    fmt_code = fmt;
  end

  assert_ext_wins_R1: assert property (@(posedge clk) disable iff (!rst_n)
    ext_los |-> los_out);
  assert_int_masked_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctrl_q[CB_LOSEN] && !ext_los) |-> !los_out);
  assert_ctrl_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(ctrl_q));
endmodule

// File: rtl/fci_irq_gate.sv
module fci_irq_gate #(
  parameter int NUM_SRC = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               en_wr,
  input  logic [NUM_SRC-1:0] en_wdata,
  input  logic               stat_rd,
  input  logic               auto_dis,
  input  logic [NUM_SRC-1:0] src_evt,
  output logic [NUM_SRC-1:0] en_q,
  output logic [NUM_SRC-1:0] stat_q,
  output logic               irq
);
  for (genvar gi = 0; gi < NUM_SRC; gi++) begin : g_src
    logic s_q, s_d;
    logic e_q, e_d, e_ce, serviced;

    always_comb begin
      serviced = auto_dis & stat_rd & s_q & e_q;
      s_d      = src_evt[gi] | (s_q & ~stat_rd);
      e_ce     = en_wr | serviced;
      e_d      = en_wr ? en_wdata[gi] : 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        s_q <= 1'b0;
        e_q <= 1'b0;
      end else begin
        s_q <= s_d;
        if (e_ce) e_q <= e_d;
      end
    end

    assign stat_q[gi] = s_q;
    assign en_q[gi]   = e_q;

    assert_evt_sets_R6: assert property (@(posedge clk) disable iff (!rst_n)
      src_evt[gi] |=> stat_q[gi]);
    assert_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (stat_q[gi] && !stat_rd) |=> stat_q[gi]);
    assert_en_only_wr_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (!auto_dis && !en_wr) |=> $stable(en_q[gi]));
    assert_autoclr_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (auto_dis && stat_rd && stat_q[gi] && en_q[gi] && !en_wr) |=> !en_q[gi]);
  end

  always_comb irq = |(stat_q & en_q);
endmodule

// File: rtl/framer_ctl_irq.sv
module framer_ctl_irq
  import fci_pkg::*;
#(
  parameter int NUM_SRC = 8,
  parameter int DATA_W  = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               bus_sel,
  input  logic               bus_wr,
  input  logic [1:0]         bus_addr,
  input  logic [DATA_W-1:0]  bus_wdata,
  output logic [DATA_W-1:0]  bus_rdata,
  input  logic               ext_los,
  input  logic               int_los,
  input  logic [NUM_SRC-1:0] src_evt,
  output logic               los_out,
  output logic               fa_rst,
  output logic [1:0]         fmt_code,
  output logic               irq
);
  logic               rst_sync_n;
  logic               wr_ctrl, wr_ien, rd_stat, rd_any;
  logic [DATA_W-1:0]  ctrl_q;
  logic [NUM_SRC-1:0] en_q, stat_q;
  logic               auto_dis;
  logic [DATA_W-1:0]  en_ext, stat_ext;

  fci_rst_sync #(.STAGES(2)) u_rst (
    .clk(clk), .arst_n(rst_n), .rst_n_o(rst_sync_n)
  );

  always_comb begin
    rd_any  = bus_sel & ~bus_wr;
    wr_ctrl = bus_sel & bus_wr & (bus_addr == ADDR_CTRL);
    wr_ien  = bus_sel & bus_wr & (bus_addr == ADDR_IEN);
    rd_stat = rd_any & (bus_addr == ADDR_STAT);
  end

  fci_ctrl_reg #(.DATA_W(DATA_W)) u_ctrl (
    .clk(clk), .rst_n(rst_sync_n), .wr_en(wr_ctrl), .wdata(bus_wdata),
    .ext_los(ext_los), .int_los(int_los), .ctrl_q(ctrl_q),
    .los_out(los_out), .fa_rst(fa_rst), .auto_dis(auto_dis),
    .fmt_code(fmt_code)
  );

  fci_irq_gate #(.NUM_SRC(NUM_SRC)) u_irq (
    .clk(clk), .rst_n(rst_sync_n), .en_wr(wr_ien),
    .en_wdata(bus_wdata[NUM_SRC-1:0]), .stat_rd(rd_stat),
    .auto_dis(auto_dis), .src_evt(src_evt), .en_q(en_q),
    .stat_q(stat_q), .irq(irq)
  );

  always_comb begin
    en_ext   = '0;
    stat_ext = '0;
    en_ext[NUM_SRC-1:0]   = en_q;
    stat_ext[NUM_SRC-1:0] = stat_q;
    bus_rdata = '0;
    if (rd_any) begin
      unique case (bus_addr)
        ADDR_CTRL: bus_rdata = ctrl_q;
        ADDR_IEN:  bus_rdata = en_ext;
        ADDR_STAT: bus_rdata = stat_ext;
        default:   bus_rdata = '0;
      endcase
    end
  end

  assert_reset_quiet_R4: assert property (@(posedge clk)
    !rst_sync_n |-> (!irq && !fa_rst && fmt_code == 2'd0));
  assert_irq_needs_src_R7: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (stat_q == '0) |-> !irq);
  assert_idle_bus_R11: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !rd_any |-> (bus_rdata == '0));
endmodule

// File: tb/framer_ctl_irq_test.sv
module framer_ctl_irq_test;
  localparam int NS = 6;
  localparam int DW = 8;

  logic          clk;
  logic          rst_n;
  logic          bus_sel, bus_wr;
  logic [1:0]    bus_addr;
  logic [DW-1:0] bus_wdata, bus_rdata;
  logic          ext_los, int_los;
  logic [NS-1:0] src_evt;
  logic          los_out, fa_rst, irq;
  logic [1:0]    fmt_code;

  int checks = 0;
  int failures = 0;
  logic [NS-1:0] ev_hold = '0;

  logic [DW-1:0] m_ctrl;
  logic [NS-1:0] m_en, m_stat;

  framer_ctl_irq #(.NUM_SRC(NS), .DATA_W(DW)) uut (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .ext_los(ext_los), .int_los(int_los), .src_evt(src_evt),
    .los_out(los_out), .fa_rst(fa_rst), .fmt_code(fmt_code), .irq(irq)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  // reference model built from the requirements
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_ctrl <= '0; m_en <= '0; m_stat <= '0;
    end else begin
      if (bus_sel && bus_wr && bus_addr == 2'd0) m_ctrl <= bus_wdata;
      if (bus_sel && !bus_wr && bus_addr == 2'd2) begin
        m_stat <= src_evt;
        if (m_ctrl[3]) m_en <= m_en & ~(m_stat & m_en);
      end else begin
        m_stat <= m_stat | src_evt;
      end
      if (bus_sel && bus_wr && bus_addr == 2'd1) m_en <= bus_wdata[NS-1:0];
    end
  end

  function automatic logic [DW-1:0] exp_read(logic [1:0] a);
    logic [DW-1:0] v;
    v = '0;
    case (a)
      2'd0: v = m_ctrl;
      2'd1: v[NS-1:0] = m_en;
      2'd2: v[NS-1:0] = m_stat;
      default: v = '0;
    endcase
    return v;
  endfunction

  function automatic logic exp_los(logic e, logic i, logic [DW-1:0] c);
    return e | (c[5] & i);
  endfunction

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] expv);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
    end
  endtask

  task automatic cmp_outs();
    chk(irq == |(m_stat & m_en), "R7 irq", irq, |(m_stat & m_en));
    chk(fa_rst == m_ctrl[4], "R3 fa_rst", fa_rst, m_ctrl[4]);
    chk(fmt_code == {m_ctrl[6], m_ctrl[2]}, "R5 fmt", fmt_code, {m_ctrl[6], m_ctrl[2]});
    chk(los_out == exp_los(ext_los, int_los, m_ctrl), "R1 R2 los", los_out,
        exp_los(ext_los, int_los, m_ctrl));
  endtask

  // one cycle: check outputs, drive new inputs, check read data
  task automatic tick(input logic sel, input logic wr, input logic [1:0] a,
                      input logic [DW-1:0] wd, input logic [NS-1:0] ev,
                      input logic el, input logic il);
    @(negedge clk);
    cmp_outs();
    bus_sel = sel; bus_wr = wr; bus_addr = a; bus_wdata = wd;
    src_evt = ev | ev_hold; ext_los = el; int_los = il;
    #1;
    if (sel && !wr)
      chk(bus_rdata == exp_read(a), "R10 R11 rdata", bus_rdata, exp_read(a));
    else
      chk(bus_rdata == '0, "R11 idle rdata", bus_rdata, 0);
  endtask

  task automatic idle(input int n);
    for (int k = 0; k < n; k++) tick(0, 0, 2'd0, '0, '0, 0, 0);
  endtask

  task automatic wr(input logic [1:0] a, input logic [DW-1:0] d);
    tick(1, 1, a, d, '0, 0, 0);
  endtask

  task automatic rd(input logic [1:0] a);
    tick(1, 0, a, '0, '0, 0, 0);
  endtask

  task automatic finish_run();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  initial begin
    #(4 * 150000);
    failures++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    void'($urandom(32'd20240611));
    rst_n = 1'b0;
    bus_sel = 0; bus_wr = 0; bus_addr = '0; bus_wdata = '0;
    src_evt = '0; ext_los = 0; int_los = 0;
    repeat (3) @(negedge clk);
    #1;
    chk(irq == 0 && fa_rst == 0 && fmt_code == 0, "R4 reset outputs",
        {irq, fa_rst, fmt_code}, 0);
    rst_n = 1'b1;
    idle(4);

    // R4 register defaults
    rd(2'd0); chk(bus_rdata == 0, "R4 ctrl default", bus_rdata, 0);
    rd(2'd1); chk(bus_rdata == 0, "R4 enable default", bus_rdata, 0);

    // R1 / R2 loss-of-signal merge
    wr(2'd0, 8'h00);
    tick(0, 0, 2'd0, '0, '0, 0, 1); chk(los_out == 0, "R2 masked int_los", los_out, 0);
    tick(0, 0, 2'd0, '0, '0, 1, 0); chk(los_out == 1, "R1 ext_los", los_out, 1);
    wr(2'd0, 8'h20);
    tick(0, 0, 2'd0, '0, '0, 0, 1); chk(los_out == 1, "R2 int_los enabled", los_out, 1);
    tick(0, 0, 2'd0, '0, '0, 1, 0); chk(los_out == 1, "R1 ext_los with enable", los_out, 1);

    // R5 every format code
    for (int f = 0; f < 4; f++) begin
      wr(2'd0, {1'b0, f[1], 3'b000, f[0], 2'b00});
      idle(1);
      chk(fmt_code == f[1:0], "R5 format code", fmt_code, f[1:0]);
    end

    // R3 framing reset toggle keeps other contents
    wr(2'd1, 8'h15);
    wr(2'd0, 8'hDB);
    idle(1); chk(fa_rst == 1, "R3 reset entered", fa_rst, 1);
    wr(2'd0, 8'hCB);
    idle(1); chk(fa_rst == 0, "R3 reset left", fa_rst, 0);
    rd(2'd0); chk(bus_rdata == 8'hCB, "R3 R10 ctrl kept", bus_rdata, 8'hCB);
    rd(2'd1); chk(bus_rdata == 8'h15, "R3 enable kept", bus_rdata, 8'h15);

    // R11 writes to status and unused address
    wr(2'd0, 8'h00); wr(2'd1, 8'h00);
    wr(2'd2, 8'hFF); wr(2'd3, 8'hFF);
    rd(2'd2); chk(bus_rdata == 0, "R11 status write ignored", bus_rdata, 0);
    rd(2'd3); chk(bus_rdata == 0, "R11 unused read", bus_rdata, 0);
    rd(2'd0); chk(bus_rdata == 0, "R11 ctrl untouched", bus_rdata, 0);

    // R6 event on the edge of a status read is kept
    tick(1, 0, 2'd2, '0, 6'b000001, 0, 0);
    idle(1);
    rd(2'd2); chk(bus_rdata == 8'h01, "R6 same-edge event", bus_rdata, 8'h01);
    idle(1);
    rd(2'd2); chk(bus_rdata == 8'h00, "R6 cleared by read", bus_rdata, 0);

    // R8 stuck source, default mode: interrupt persists
    wr(2'd1, 8'h04);
    ev_hold = 6'b000100;
    idle(3); chk(irq == 1, "R7 stuck irq", irq, 1);
    rd(2'd2); idle(1); chk(irq == 1, "R8 irq persists", irq, 1);
    rd(2'd2); idle(2); chk(irq == 1, "R8 irq persists again", irq, 1);
    rd(2'd1); chk(bus_rdata == 8'h04, "R8 enable unchanged", bus_rdata, 8'h04);

    // R9 auto-disable: one interrupt only
    wr(2'd0, 8'h08);
    idle(1);
    rd(2'd2); idle(1); chk(irq == 0, "R9 irq dropped", irq, 0);
    idle(20); chk(irq == 0, "R9 no re-interrupt", irq, 0);
    rd(2'd1); chk(bus_rdata == 8'h00, "R9 enable cleared", bus_rdata, 0);
    wr(2'd1, 8'h04); idle(1); chk(irq == 1, "R9 re-armed", irq, 1);
    ev_hold = '0;
    rd(2'd2); idle(1);
    rd(2'd2); idle(1); chk(irq == 0, "R9 released", irq, 0);

    // random traffic against the model
    for (int n = 0; n < 4000; n++) begin
      logic [2:0] op;
      logic [NS-1:0] ev;
      op = 3'($urandom_range(0, 7));
      ev = ($urandom_range(0, 3) == 0) ? NS'($urandom) : '0;
      if ($urandom_range(0, 200) == 0) ev_hold = NS'(1 << $urandom_range(0, NS - 1));
      if ($urandom_range(0, 150) == 0) ev_hold = '0;
      tick(op < 5, op < 2, 2'($urandom), DW'($urandom), ev,
           1'($urandom), 1'($urandom));
    end
    ev_hold = '0;
    idle(2);

    // R4 hardware reset mid-run
    wr(2'd0, 8'h5D); wr(2'd1, 8'h3F);
    tick(0, 0, 2'd0, '0, 6'h3F, 0, 0);
    @(negedge clk);
    bus_sel = 1; bus_wr = 0; bus_addr = 2'd0; src_evt = '0;
    rst_n = 1'b0;
    #1;
    chk(bus_rdata == 0, "R4 ctrl cleared", bus_rdata, 0);
    chk(irq == 0 && fa_rst == 0 && fmt_code == 0, "R4 outputs cleared",
        {irq, fa_rst, fmt_code}, 0);
    bus_addr = 2'd1; #1;
    chk(bus_rdata == 0, "R4 enable cleared", bus_rdata, 0);
    bus_addr = 2'd2; #1;
    chk(bus_rdata == 0, "R4 status cleared", bus_rdata, 0);
    bus_sel = 0;
    @(negedge clk);
    rst_n = 1'b1;
    idle(4);
    finish_run();
  end
endmodule